// File: doc/BRIEF.md
# Eight-channel pulse generator with scaled interrupts

The block holds a bank of pulse-width channels programmed over an APB slave port. A shared prescaler divides the clock into an advance strobe. Each channel runs a period counter on that strobe and has two compare points. The first point switches the channel output on and the second switches it off. A pulse can therefore start and end inside one period. A compare point set to all ones never matches, which parks the output in its idle level.

Each channel chooses which of its events can interrupt: the on-point match, the period wrap, or neither. Selected events pass through a 6-bit divider, so an interrupt is raised only on every (N+1)-th event. Every selected event also pulses the channel's bit of a tick vector. A raised interrupt sets a sticky pending bit that software clears by writing one to it. The interrupt line is the OR of all pending bits.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads zero except the two constant identification words, and pwm_o, tick_o and irq_o are low.
- R2: Register map:
  - Common registers: 0x00 bit 0 is the core enable, 0x04 bits 15:0 hold the prescaler reload, 0x08 holds the pending bits, 0x0C reads the channel count and 0x10 reads the counter width (16).
  - Per-channel registers sit at base 0x20 + 0x10*i: +0x00 is the period (bits 15:0), +0x04 holds the on point in bits 15:0 and the off point in bits 31:16, and +0x0C is the control register.
  - Control register fields: bit 0 is the channel enable, bits 2:1 the interrupt select and bits 8:3 the divider limit N.
  - The per-channel +0x08 word and offsets 0x14 to 0x1C always read zero.
- R3: While the core enable is set, the advance strobe fires once every reload+1 clocks. While it is clear, no channel counter advances and no tick occurs.
- R4: A channel counter counts 0,1,…,P on advance strobes and returns to 0 on the strobe after reaching P. The period is therefore P+1 strobes, and the return to 0 is the period event.
- R5: The output goes high one clock after a strobe at which the counter equals the on point. It goes low one clock after a strobe at which the counter equals the off point. With on point a < off point b ≤ P, the output is high for b−a strobes in every period. If both points match at once, off wins.
- R6: A compare point of 0xFFFF never matches. With the on point at 0xFFFF the output stays low. With the off point at 0xFFFF the output stays high once switched on.
- R7: Interrupt select 01 chooses the on-point match and 10 chooses the period event. Selects 00 and 11 choose no event.
- R8: With divider limit N, an interrupt is raised on every (N+1)-th selected event. The divider restarts from zero when the channel is disabled.
- R9: Every selected event gives a one-clock pulse on tick_o bit i, where i is the channel index. The pulse is in the same clock as the event's pending update, and no other bit pulses.
- R10: A raised interrupt sets pending bit i. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. irq_o is the OR of the pending bits.
- R11: If a clearing write and a new interrupt for the same bit land on the same clock, the bit stays set.
- R12: A disabled channel holds its counter at 0, its output low and its divider at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pwm_o | output | 8 | Channel pulse outputs |
| tick_o | output | 8 | Per-channel selected-event pulses |
| irq_o | output | 1 | OR of pending bits |

## Verification
A wrong counter or compare state shows at pwm_o within one period of the channel: the high time per period or the period length changes. Those values are measured over whole periods and compared against b−a and (P+1)(reload+1). A wrong event select or divider state shows at tick_o and irq_o within N+1 periods. It appears as ticks that are not aligned with the matching pwm_o edge, or as an interrupt raised after the wrong number of ticks. The clear/set race is placed on the exact clock of a known event, so a wrong priority drops irq_o in the very next cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ICNT_W = 6;

  typedef enum logic [1:0] {
    ISEL_NONE = 2'b00,
    ISEL_CMP  = 2'b01,
    ISEL_PER  = 2'b10,
    ISEL_OFF  = 2'b11
  } isel_e;

  typedef struct packed {
    logic [ICNT_W-1:0] icount;
    isel_e             isel;
    logic              en;
  } ch_cfg_t;

  localparam int CFG_W = $bits(ch_cfg_t);

  // word index inside a 16-byte slot
  localparam logic [1:0] SUB_PER  = 2'd0;
  localparam logic [1:0] SUB_CMP  = 2'd1;
  localparam logic [1:0] SUB_DB   = 2'd2;
  localparam logic [1:0] SUB_CTRL = 2'd3;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!en_i || cnt_q == '0)   cnt_q <= reload_i;
    else                             cnt_q <= cnt_q - 1'b1;
  end

  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && reload_i != '0) |=> !tick_o);
  assert_no_tick_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          adv_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] on_i,
  input  logic [CW-1:0] off_i,
  output logic          pwm_o,
  output logic          cmp_evt_o,
  output logic          per_evt_o
);
  logic [CW-1:0] cnt_q;
  logic          pwm_q;
  logic          step, on_hit, off_hit, wrap;

  assign step    = en_i && adv_i;
  assign wrap    = cnt_q >= period_i;
  // all-ones points are parked and never match
  assign on_hit  = (cnt_q == on_i)  && (on_i  != '1);
  assign off_hit = (cnt_q == off_i) && (off_i != '1);

  assign cmp_evt_o = step && on_hit;
  assign per_evt_o = step && wrap;
  assign pwm_o     = pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else if (step) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (off_hit)     pwm_q <= 1'b0;
      else if (on_hit) pwm_q <= 1'b1;
    end
  end

  assert_wrap_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_evt_o && en_i) |=> (cnt_q == '0));
  assert_rise_on_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_o) |-> $past(cmp_evt_o));
  assert_disabled_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pwm_o && cnt_q == '0));
endmodule

// File: rtl/pwm_irq_scaler.sv
module pwm_irq_scaler #(
  parameter int IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          evt_i,
  input  logic [IW-1:0] limit_i,
  output logic          raise_o,
  output logic          tick_o
);
  logic [IW-1:0] cnt_q;
  logic          tick_q;

  assign raise_o = evt_i && (cnt_q >= limit_i);
  assign tick_o  = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= evt_i;
      if (!en_i)        cnt_q <= '0;
      else if (raise_o) cnt_q <= '0;
      else if (evt_i)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_raise_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_o |=> (cnt_q == '0));
  assert_tick_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> tick_o);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           psel_i,
  input  logic           penable_i,
  input  logic           pwrite_i,
  input  logic [AW-1:0]  paddr_i,
  input  logic [31:0]    pwdata_i,
  output logic [31:0]    prdata_o,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] tick_o,
  output logic           irq_o
);
  localparam int SEG_W   = AW - 4;
  localparam int CH_BASE = 2;

  logic                core_en_q;
  logic [CW-1:0]       reload_q;
  logic [NCH-1:0]      pend_q;
  logic [CW-1:0]       per_q [NCH];
  logic [CW-1:0]       on_q  [NCH];
  logic [CW-1:0]       off_q [NCH];
  ch_cfg_t             cfg_q [NCH];

  logic                adv;
  logic [NCH-1:0]      raise, cmp_evt, per_evt, sel_evt;

  logic                wr_en;
  logic [SEG_W-1:0]    seg;
  logic [1:0]          sub;
  logic [SEG_W-1:0]    ch_idx;
  logic                ch_hit;
  logic [NCH-1:0]      pend_clr;

  assign wr_en  = psel_i && penable_i && pwrite_i;
  assign seg    = paddr_i[AW-1:4];
  assign sub    = paddr_i[3:2];
  assign ch_idx = seg - SEG_W'(CH_BASE);
  assign ch_hit = (seg >= SEG_W'(CH_BASE)) && (int'(ch_idx) < NCH);

  assign pend_clr = (wr_en && seg == '0 && sub == 2'd2) ? pwdata_i[NCH-1:0] : '0;

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_en_q <= 1'b0;
      reload_q  <= '0;
      for (int i = 0; i < NCH; i++) begin
        per_q[i] <= '0;
        on_q[i]  <= '0;
        off_q[i] <= '0;
        cfg_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (seg == '0) begin
        if (sub == 2'd0) core_en_q <= pwdata_i[0];
        if (sub == 2'd1) reload_q  <= pwdata_i[CW-1:0];
      end
      for (int i = 0; i < NCH; i++) begin
        if (ch_hit && int'(ch_idx) == i) begin
          case (sub)
            SUB_PER:  per_q[i] <= pwdata_i[CW-1:0];
            SUB_CMP: begin
              on_q[i]  <= pwdata_i[CW-1:0];
              off_q[i] <= pwdata_i[16+CW-1:16];
            end
            SUB_CTRL: cfg_q[i] <= ch_cfg_t'(pwdata_i[CFG_W-1:0]);
            default: ;
          endcase
        end
      end
    end
  end

  // new interrupt beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr) | raise;
  end

  assign irq_o = |pend_q;

  // read mux
  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      if (seg == '0) begin
        case (sub)
          2'd0: prdata_o = 32'(core_en_q);
          2'd1: prdata_o = 32'(reload_q);
          2'd2: prdata_o = 32'(pend_q);
          default: prdata_o = 32'(NCH);
        endcase
      end else if (seg == SEG_W'(1)) begin
        if (sub == 2'd0) prdata_o = 32'(CW);
      end else if (ch_hit) begin
        for (int i = 0; i < NCH; i++) begin
          if (int'(ch_idx) == i) begin
            case (sub)
              SUB_PER:  prdata_o = 32'(per_q[i]);
              SUB_CMP:  prdata_o = (32'(off_q[i]) << 16) | 32'(on_q[i]);
              SUB_CTRL: prdata_o = 32'(cfg_q[i]);
              default:  prdata_o = '0;
            endcase
          end
        end
      end
    end
  end

  pwm_prescaler #(.W(CW)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (core_en_q),
    .reload_i (reload_q),
    .tick_o   (adv)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (cfg_q[g].en),
      .adv_i     (adv),
      .period_i  (per_q[g]),
      .on_i      (on_q[g]),
      .off_i     (off_q[g]),
      .pwm_o     (pwm_o[g]),
      .cmp_evt_o (cmp_evt[g]),
      .per_evt_o (per_evt[g])
    );

    always_comb begin
      unique case (cfg_q[g].isel)
        ISEL_CMP: sel_evt[g] = cmp_evt[g];
        ISEL_PER: sel_evt[g] = per_evt[g];
        default:  sel_evt[g] = 1'b0;
      endcase
    end

    pwm_irq_scaler #(.IW(ICNT_W)) u_isc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (cfg_q[g].en),
      .evt_i   (sel_evt[g]),
      .limit_i (cfg_q[g].icount),
      .raise_o (raise[g]),
      .tick_o  (tick_o[g])
    );

    assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raise[g] |=> pend_q[g]);
    assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_clr[g] && !raise[g]) |=> !pend_q[g]);
    assert_tick_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raise[g] |=> (tick_o[g] && pend_q[g]));
  end
endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int NCH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [7:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic [NCH-1:0] pwm_o, tick_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  pwm_bank u_pwm_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel_i), .penable_i(penable_i),
    .pwrite_i(pwrite_i), .paddr_i(paddr_i), .pwdata_i(pwdata_i),
    .prdata_o(prdata_o), .pwm_o(pwm_o), .tick_o(tick_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // called at a falling edge; returns at the falling edge after the access edge
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel_i = 1; penable_i = 0; pwrite_i = 1; paddr_i = a; pwdata_i = d;
    @(negedge clk_i); penable_i = 1;
    @(negedge clk_i); psel_i = 0; penable_i = 0; pwrite_i = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel_i = 1; penable_i = 0; pwrite_i = 0; paddr_i = a;
    @(negedge clk_i); penable_i = 1;
    #5 d = prdata_o;
    @(negedge clk_i); psel_i = 0; penable_i = 0;
  endtask

  function automatic logic [7:0] cha(input int ch, input int off);
    return 8'(32 + 16 * ch + off);
  endfunction

  function automatic logic [31:0] cfgw(input int en, input int sel, input int n);
    return 32'(en | (sel << 1) | (n << 3));
  endfunction

  int hi   [NCH];
  int tk   [NCH];
  int rose_tk [NCH];
  int fell_tk [NCH];
  int tog  [NCH];

  task automatic measure(input int len);
    logic [NCH-1:0] prev;
    prev = pwm_o;
    for (int c = 0; c < NCH; c++) begin
      hi[c] = 0; tk[c] = 0; rose_tk[c] = 0; fell_tk[c] = 0; tog[c] = 0;
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk_i);
      for (int c = 0; c < NCH; c++) begin
        if (pwm_o[c]) hi[c]++;
        if (pwm_o[c] != prev[c]) tog[c]++;
        if (tick_o[c]) begin
          tk[c]++;
          if (pwm_o[c] && !prev[c]) rose_tk[c]++;
          if (!pwm_o[c] && prev[c]) fell_tk[c]++;
        end
      end
      prev = pwm_o;
    end
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(pwm_o == 0 && tick_o == 0 && irq_o == 0, "R1 outputs", {pwm_o, tick_o, irq_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    apb_rd(8'h00, rd); check(rd == 0, "R1 core ctrl", rd, 0);
    apb_rd(8'h08, rd); check(rd == 0, "R1 pending", rd, 0);
    apb_rd(cha(3, 0), rd); check(rd == 0, "R1 period", rd, 0);
    apb_rd(cha(3, 12), rd); check(rd == 0, "R1 control", rd, 0);

    // R2 map
    apb_rd(8'h0C, rd); check(rd == NCH, "R2 channel count", rd, NCH);
    apb_rd(8'h10, rd); check(rd == 16, "R2 counter width", rd, 16);
    apb_wr(cha(7, 0), 32'hFFFF_1234); apb_rd(cha(7, 0), rd);
    check(rd == 32'h1234, "R2 period", rd, 32'h1234);
    apb_wr(cha(7, 4), 32'hABCD_5678); apb_rd(cha(7, 4), rd);
    check(rd == 32'hABCD_5678, "R2 compare", rd, 32'hABCD_5678);
    apb_wr(cha(7, 12), 32'hFFFF_FFFE); apb_rd(cha(7, 12), rd);
    check(rd == 32'h1FE, "R2 control", rd, 32'h1FE);
    apb_wr(cha(7, 12), 0);
    apb_wr(cha(7, 8), 32'hFFFF_FFFF); apb_rd(cha(7, 8), rd);
    check(rd == 0, "R2 dead word", rd, 0);
    for (int a = 8'h14; a <= 8'h1C; a += 4) begin
      apb_rd(8'(a), rd); check(rd == 0, "R2 reserved", rd, 0);
    end
    apb_wr(8'h04, 32'h0001_0ABC); apb_rd(8'h04, rd);
    check(rd == 32'h0ABC, "R2 reload", rd, 32'h0ABC);

    // sweep: R4 R5 R6 R7 R9
    for (int pi = 0; pi < 3; pi++) begin
      for (int ri = 0; ri < 2; ri++) begin
        int p, r, a, b, per_len;
        p = 6 + 5 * pi; r = 2 * ri; a = 1 + pi; b = p / 2;
        per_len = (p + 1) * (r + 1);
        apb_wr(8'h00, 0);
        for (int c = 0; c < 4; c++) apb_wr(cha(c, 12), 0);
        apb_wr(8'h08, 32'hFF);
        apb_wr(8'h04, 32'(r));
        for (int c = 0; c < 4; c++) apb_wr(cha(c, 0), 32'(p));
        apb_wr(cha(0, 4), 32'((b << 16) | a));
        apb_wr(cha(1, 4), 32'((p << 16) | 0));
        apb_wr(cha(2, 4), 32'((2 << 16) | 16'hFFFF));
        apb_wr(cha(3, 4), 32'((16'hFFFF << 16) | 2));
        apb_wr(cha(0, 12), cfgw(1, 1, 0));
        apb_wr(cha(1, 12), cfgw(1, 2, 0));
        apb_wr(cha(2, 12), cfgw(1, 0, 0));
        apb_wr(cha(3, 12), cfgw(1, 3, 0));
        apb_wr(8'h00, 1);
        repeat (2 * per_len + 3) @(negedge clk_i);
        measure(3 * per_len);
        check(hi[0] == 3 * (b - a) * (r + 1), "R5 high time", hi[0], 3 * (b - a) * (r + 1));
        check(hi[1] == 3 * p * (r + 1), "R4 period length", hi[1], 3 * p * (r + 1));
        check(hi[2] == 0, "R6 parked on point", hi[2], 0);
        check(hi[3] == 3 * per_len, "R6 parked off point", hi[3], 3 * per_len);
        check(tk[0] == 3 && rose_tk[0] == 3, "R7 compare select", tk[0] * 16 + rose_tk[0], 3 * 16 + 3);
        check(tk[1] == 3 && fell_tk[1] == 3, "R7 period select", tk[1] * 16 + fell_tk[1], 3 * 16 + 3);
        check(tk[2] == 0 && tk[3] == 0, "R7 no-event selects", tk[2] + tk[3], 0);
        check(tk[4] + tk[5] + tk[6] + tk[7] == 0, "R9 tick index", tk[4] + tk[5] + tk[6] + tk[7], 0);
      end
    end

    // R3 core disabled freezes everything
    apb_wr(8'h00, 0);
    @(negedge clk_i);
    measure(60);
    check(tk[0] + tk[1] == 0 && tog[0] + tog[1] == 0, "R3 core off", tk[0] + tog[0] + tk[1] + tog[1], 0);
    apb_wr(8'h00, 1);
    measure(60);
    check(tk[0] > 0, "R3 core on again", tk[0], 1);

    // R12 channel disable
    apb_wr(cha(3, 12), 0);
    @(negedge clk_i);
    measure(60);
    check(hi[3] == 0 && tk[3] == 0, "R12 disabled channel", hi[3] + tk[3], 0);

    // R8 divider and R10 clear
    for (int ni = 0; ni < 3; ni++) begin
      int n, cnt;
      n = (ni == 0) ? 0 : (ni == 1) ? 2 : 5;
      apb_wr(8'h00, 0);
      for (int c = 0; c < 4; c++) apb_wr(cha(c, 12), 0);
      apb_wr(8'h08, 32'hFF);
      apb_wr(8'h04, 0);
      apb_wr(cha(0, 0), 4);
      apb_wr(cha(0, 4), 32'((2 << 16) | 1));
      apb_wr(cha(0, 12), cfgw(1, 1, n));
      check(irq_o == 0, "R10 cleared before run", irq_o, 0);
      apb_wr(8'h00, 1);
      cnt = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk_i);
        if (tick_o[0]) cnt++;
        if (irq_o) break;
      end
      check(cnt == n + 1, "R8 events per interrupt", cnt, n + 1);
      if (n == 5) begin
        apb_rd(8'h08, rd); check(rd == 1, "R10 pending bit", rd, 1);
        apb_wr(8'h08, 32'hFE);
        check(irq_o == 1, "R10 write zero keeps", irq_o, 1);
        apb_wr(8'h08, 32'h01);
        check(irq_o == 0, "R10 write one clears", irq_o, 0);
      end
    end

    // R11 clear vs new interrupt: N=0, event every 5 clocks
    apb_wr(cha(0, 12), cfgw(1, 1, 0));
    while (!tick_o[0]) @(negedge clk_i);
    @(negedge clk_i);
    apb_wr(8'h08, 32'h01);
    check(irq_o == 0, "R11 control clear off-event", irq_o, 0);
    while (!tick_o[0]) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    apb_wr(8'h08, 32'h01);
    check(irq_o == 1, "R11 set wins over clear", irq_o, 1);
    check(tick_o[0] == 1, "R9 tick on event clock", tick_o[0], 1);

    finish_run();
  end
endmodule